// File: doc/BRIEF.md
# Compare-Terminated Byte String Loader

This block moves a byte string from memory into a 32-entry register file. It makes one single-byte memory read per step. A start pulse supplies the start address, the first target register, a byte count, a compare byte and the indices of two protected registers. The block then reads bytes from consecutive addresses. It packs each byte into the next byte lane of the current register, filling from the most significant lane down. When a register's last lane is filled, it moves on to the next register index, wrapping from 31 to 0.

Each byte is written through a byte-strobed write port, so the other lanes of that register keep their contents. A write aimed at a protected register is dropped, but the byte still counts and the lane still advances. If a fetched byte equals the compare byte, that byte is handled like any other and the run then ends. At the end of a run the block pulses `done` and reports two results: the number of bytes processed before termination, and a flag saying whether the run ended on a match. Address translation happens outside the block.

Top module: `cmp_string_loader`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. A start pulse seen while `busy` is high is ignored and does not change the run in progress or its results.
- R2: The first byte goes to lane 3 (bits 31:24, strobe 4'b1000), and each later byte goes one lane lower (23:16, 15:8, 7:0). After lane 0, the next byte goes to lane 3 of register index + 1, taken modulo 32.
- R3: Every register write has exactly one strobe bit set, and `rf_wr_data` carries the byte in all four lanes. Lanes that are not strobed keep their previous values.
- R4: No write is issued when the current register equals `prot_b_reg`, or equals `prot_a_reg` while `prot_a_reg` is nonzero. Both indices are sampled at start. A suppressed byte still counts and still advances the lane.
- R5: A fetched byte equal to `cmp_byte` is written (unless R4 suppresses it), and then the run ends with `matched` = 1.
- R6: `proc_count` is the 0-based position of the matching byte when the run ends on a match. Otherwise it is the full `byte_count`, with `matched` = 0.
- R7: The first memory read uses `start_addr`, and each later read uses the previous address + 1, modulo 2^32. A run issues exactly one read per byte processed.
- R8: A `byte_count` of 0 gives `done` in the cycle after start, with `proc_count` = 0, `matched` = 0, no memory read and no register write.
- R9: `mem_req` rises in the cycle after an accepted start. A write is issued in the cycle after `mem_rvalid`. The next read or `done` follows in the cycle after that write. A run of k bytes with one-cycle memory therefore takes 3k+1 cycles from start to `done`, and `done` lasts one cycle.
- R10: After reset, `busy`, `done`, `mem_req`, `rf_wr_en`, `matched` and `proc_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_addr | input | 32 | Address of the first byte |
| start_reg | input | 5 | First target register index |
| prot_a_reg | input | 5 | Protected index A (no protection when 0) |
| prot_b_reg | input | 5 | Protected index B (always protected) |
| byte_count | input | 7 | Maximum number of bytes to load |
| cmp_byte | input | 8 | Terminating byte value |
| busy | output | 1 | A run is in progress |
| mem_req | output | 1 | One-byte read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_idx | output | 5 | Register index written |
| rf_wr_strb | output | 4 | Byte lane strobe, bit 3 = bits 31:24 |
| rf_wr_data | output | 32 | Byte replicated into all lanes |
| done | output | 1 | One-cycle end-of-run pulse |
| matched | output | 1 | Run ended on the compare byte |
| proc_count | output | 7 | Bytes-processed result |

## Verification
Every result of this block has a fixed due cycle. The read request appears one cycle after start, the lane write one cycle after the read data, and `done` one cycle after the last write, so a run of k bytes finishes 3k+1 cycles after start. A zero-count run finishes 1 cycle after start. The bench drives on falling edges and counts rising edges until `done`, and it checks that count against 3k+1. The directed latency test samples `mem_req`, `rf_wr_en` and `done` at the exact falling edge each is due. Register contents, read counts and the last address are compared only after `done`.

// File: rtl/bsl_pkg.sv
// Package for the compare-terminated byte string loader.
// Holds the control state encoding that the controller uses.
package bsl_pkg;

    // Control states: idle, issue read, wait for data, write lane
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } ldr_state_e;

endpackage

// File: rtl/bsl_lane_seq.sv
// Lane sequencer: tracks the target register index and the byte lane.
// Starts at the top lane of the start register. Each step moves one lane
// down; after lane 0 it returns to the top lane of the next register,
// with the index wrapping at 2^IDX_W.
// Assumes LANES >= 2 and the register count is a power of two.
module bsl_lane_seq #(
    parameter int IDX_W = 5,
    parameter int LANES = 4,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              step,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [LANE_W-1:0] cur_lane,
    output logic [LANES-1:0]  lane_strb
);

    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

    // Load on launch, then walk lanes downward and registers upward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx  <= '0;
            cur_lane <= TOP_LANE;
        end else if (launch) begin
            cur_idx  <= start_idx;
            cur_lane <= TOP_LANE;
        end else if (step) begin
            if (cur_lane == '0) begin
                cur_lane <= TOP_LANE;
                cur_idx  <= cur_idx + IDX_W'(1);
            end else begin
                cur_lane <= cur_lane - LANE_W'(1);
            end
        end
    end

    // One strobe bit per lane, decoded from the lane counter
    for (genvar g = 0; g < LANES; g++) begin : g_strb
        assign lane_strb[g] = (cur_lane == LANE_W'(g));
    end

endmodule

// File: rtl/bsl_write_guard.sv
// Write guard: captures the two protected register indices at launch and
// reports whether the current register may be written. Index B always
// blocks; index A blocks only when it is nonzero.
module bsl_write_guard #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [IDX_W-1:0] prot_a_in,
    input  logic [IDX_W-1:0] prot_b_in,
    input  logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] prot_a_q,
    output logic [IDX_W-1:0] prot_b_q,
    output logic             allow
);

    // Hold the protected indices for the whole run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_a_q <= '0;
            prot_b_q <= '0;
        end else if (launch) begin
            prot_a_q <= prot_a_in;
            prot_b_q <= prot_b_in;
        end
    end

    // Permission for the register currently addressed
    always_comb begin
        allow = (cur_idx != prot_b_q) &&
                ((prot_a_q == '0) || (cur_idx != prot_a_q));
    end

endmodule

// File: rtl/bsl_fetch_ctl.sv
// Fetch controller: runs the request / wait / write loop, one byte per
// pass. Holds the address and byte position, compares each byte with the
// terminator, and registers the results and the done pulse.
// Assumes the memory returns exactly one mem_rvalid per request; a
// mem_rvalid outside the wait state is ignored.
module bsl_fetch_ctl
    import bsl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [7:0]        cmp_byte,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              launch,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              st_write,
    output logic              seq_step,
    output logic [7:0]        byte_q,
    output logic [CNT_W-1:0]  tot_q,
    output logic              done,
    output logic              matched,
    output logic [CNT_W-1:0]  res_count
);

    ldr_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  pos_q;
    logic [7:0]        cmp_q;
    logic [CNT_W:0]    pos_next;
    logic              hit;
    logic              last;

    // Decode of the state into handshake and step signals
    always_comb begin
        launch   = (state_q == ST_IDLE) && start;
        busy     = (state_q != ST_IDLE);
        mem_req  = (state_q == ST_REQ);
        mem_addr = addr_q;
        st_write = (state_q == ST_WRITE);
        pos_next = {1'b0, pos_q} + (CNT_W + 1)'(1);
        hit      = (byte_q == cmp_q);
        last     = (pos_next == {1'b0, tot_q});
        seq_step = st_write && !hit && !last;
    end

    // Main sequencing, operand capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            pos_q     <= '0;
            tot_q     <= '0;
            cmp_q     <= '0;
            byte_q    <= '0;
            done      <= 1'b0;
            matched   <= 1'b0;
            res_count <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= start_addr;
                        tot_q  <= byte_count;
                        cmp_q  <= cmp_byte;
                        pos_q  <= '0;
                        if (byte_count == '0) begin
                            done      <= 1'b1;
                            matched   <= 1'b0;
                            res_count <= '0;
                        end else begin
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        byte_q  <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (hit) begin
                        done      <= 1'b1;
                        matched   <= 1'b1;
                        res_count <= pos_q;
                        state_q   <= ST_IDLE;
                    end else if (last) begin
                        done      <= 1'b1;
                        matched   <= 1'b0;
                        res_count <= tot_q;
                        state_q   <= ST_IDLE;
                    end else begin
                        pos_q   <= pos_q + CNT_W'(1);
                        addr_q  <= addr_q + ADDR_W'(1);
                        state_q <= ST_REQ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmp_string_loader.sv
// Compare-terminated byte string loader, top level.
// Links the fetch controller, the lane sequencer and the write guard, and
// forms the byte-strobed register write port. The byte is replicated into
// every lane and the strobe selects the one lane to update.
// Assumes DATA_W is a multiple of 8 with at least two lanes.
module cmp_string_loader #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [IDX_W-1:0]  start_reg,
    input  logic [IDX_W-1:0]  prot_a_reg,
    input  logic [IDX_W-1:0]  prot_b_reg,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [7:0]        cmp_byte,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [LANES-1:0]  rf_wr_strb,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              done,
    output logic              matched,
    output logic [CNT_W-1:0]  proc_count
);

    logic              launch;
    logic              st_write;
    logic              seq_step;
    logic [7:0]        byte_q;
    logic [CNT_W-1:0]  tot_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [LANE_W-1:0] cur_lane;
    logic [LANES-1:0]  lane_strb;
    logic [IDX_W-1:0]  prot_a_q;
    logic [IDX_W-1:0]  prot_b_q;
    logic              allow;

    bsl_fetch_ctl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .byte_count (byte_count),
        .cmp_byte   (cmp_byte),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .launch     (launch),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .st_write   (st_write),
        .seq_step   (seq_step),
        .byte_q     (byte_q),
        .tot_q      (tot_q),
        .done       (done),
        .matched    (matched),
        .res_count  (proc_count)
    );

    bsl_lane_seq #(
        .IDX_W (IDX_W),
        .LANES (LANES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .start_idx (start_reg),
        .step      (seq_step),
        .cur_idx   (cur_idx),
        .cur_lane  (cur_lane),
        .lane_strb (lane_strb)
    );

    bsl_write_guard #(
        .IDX_W (IDX_W)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .prot_a_in (prot_a_reg),
        .prot_b_in (prot_b_reg),
        .cur_idx   (cur_idx),
        .prot_a_q  (prot_a_q),
        .prot_b_q  (prot_b_q),
        .allow     (allow)
    );

    // Register write port: gated by the guard, one lane strobed
    always_comb begin
        rf_wr_en   = st_write && allow;
        rf_wr_idx  = cur_idx;
        rf_wr_strb = lane_strb;
        rf_wr_data = {LANES{byte_q}};
    end

endmodule

// File: rtl/cmp_string_loader_chk.sv
// Checker for the compare-terminated byte string loader, bound to the
// top module. Observes ports and internal step/lane state; drives nothing.
module cmp_string_loader_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch,
    input logic [CNT_W-1:0]  byte_count,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_wr_en,
    input logic [IDX_W-1:0]  rf_wr_idx,
    input logic [LANES-1:0]  rf_wr_strb,
    input logic [IDX_W-1:0]  prot_a_q,
    input logic [IDX_W-1:0]  prot_b_q,
    input logic              seq_step,
    input logic [IDX_W-1:0]  cur_idx,
    input logic [LANE_W-1:0] cur_lane,
    input logic [CNT_W-1:0]  tot_q,
    input logic              done,
    input logic              matched,
    input logic [CNT_W-1:0]  proc_count
);

    logic [ADDR_W-1:0] prev_addr;
    logic              have_prev;

    // Remember the previous read address within one run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            have_prev <= 1'b0;
        end else if (launch) begin
            have_prev <= 1'b0;
        end else if (mem_req) begin
            prev_addr <= mem_addr;
            have_prev <= 1'b1;
        end
    end

    // R7: reads within a run step the address by one
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && have_prev) |-> (mem_addr == prev_addr + ADDR_W'(1)));

    // R3: exactly one lane strobed on every write
    p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> ($countones(rf_wr_strb) == 1));

    // R4: protected registers never written
    p_protected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> ((rf_wr_idx != prot_b_q) &&
                      ((prot_a_q == '0) || (rf_wr_idx != prot_a_q))));

    // R2: after lane 0 the next register's top lane follows
    p_lane_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step && cur_lane == '0) |=>
            (cur_lane == LANE_W'(LANES - 1) &&
             cur_idx == $past(cur_idx) + IDX_W'(1)));

    // R2: within a register lanes fill downward
    p_lane_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_step && cur_lane != '0) |=>
            (cur_lane == $past(cur_lane) - LANE_W'(1) &&
             cur_idx == $past(cur_idx)));

    // R6: a full run reports the full count
    p_full_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !matched) |-> (proc_count == tot_q));

    // R6: a matched run reports a position below the count
    p_match_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && matched) |-> (proc_count < tot_q));

    // R8: zero count finishes next cycle without any read
    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && byte_count == '0) |=>
            (done && !mem_req && !busy && proc_count == '0));

    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind cmp_string_loader cmp_string_loader_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .byte_count (byte_count),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_idx  (rf_wr_idx),
    .rf_wr_strb (rf_wr_strb),
    .prot_a_q   (prot_a_q),
    .prot_b_q   (prot_b_q),
    .seq_step   (seq_step),
    .cur_idx    (cur_idx),
    .cur_lane   (cur_lane),
    .tot_q      (tot_q),
    .done       (done),
    .matched    (matched),
    .proc_count (proc_count)
);

// File: tb/cmp_string_loader_tb.sv
// Bench for the compare-terminated byte string loader: a table of runs
// walked by one loop, then directed tests for reset, latency, zero count
// and start while busy.
module cmp_string_loader_tb_top;

    typedef struct packed {
        logic [31:0] addr;
        logic [4:0]  sreg;
        logic [4:0]  pa;
        logic [4:0]  pb;
        logic [6:0]  cnt;
        logic [7:0]  cmp;
    } vec_t;

    // Memory byte at address a is a[7:0] + a[15:8] + 0x11
    localparam vec_t VECS [0:8] = '{
        '{32'h0000_0100, 5'd3,  5'd0, 5'd0,  7'd10,  8'h1C}, // no match
        '{32'h0000_0200, 5'd8,  5'd0, 5'd1,  7'd20,  8'h18}, // match at 5
        '{32'h0000_0040, 5'd12, 5'd0, 5'd0,  7'd4,   8'h51}, // match at 0
        '{32'h0000_1000, 5'd30, 5'd5, 5'd6,  7'd12,  8'h00}, // index wrap
        '{32'h0000_0300, 5'd4,  5'd5, 5'd7,  7'd16,  8'hFF}, // both protected
        '{32'h0000_2000, 5'd0,  5'd0, 5'd9,  7'd6,   8'h33}, // reg 0 with A=0
        '{32'hFFFF_FFFE, 5'd20, 5'd0, 5'd0,  7'd5,   8'h12}, // address wrap
        '{32'h0000_0500, 5'd16, 5'd0, 5'd17, 7'd7,   8'h1C}, // match in protected reg
        '{32'h0000_7F00, 5'd1,  5'd0, 5'd0,  7'd127, 8'h8F}  // maximum count
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [4:0]  start_reg = '0;
    logic [4:0]  prot_a_reg = '0;
    logic [4:0]  prot_b_reg = '0;
    logic [6:0]  byte_count = '0;
    logic [7:0]  cmp_byte = '0;
    logic        busy, mem_req, rf_wr_en, done, matched;
    logic [31:0] mem_addr, rf_wr_data;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [4:0]  rf_wr_idx;
    logic [3:0]  rf_wr_strb;
    logic [6:0]  proc_count;

    logic [31:0] rf_dut [32];
    logic [31:0] rf_exp [32];
    int          req_cnt = 0;
    logic [31:0] last_addr = '0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    cmp_string_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_reg(start_reg), .prot_a_reg(prot_a_reg), .prot_b_reg(prot_b_reg),
        .byte_count(byte_count), .cmp_byte(cmp_byte), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
        .rf_wr_strb(rf_wr_strb), .rf_wr_data(rf_wr_data), .done(done),
        .matched(matched), .proc_count(proc_count)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] + a[15:8] + 8'h11;
    endfunction

    function automatic logic [31:0] init_val(input int i);
        return 32'hC3C3_0000 + 32'(i) * 32'h0000_0101;
    endfunction

    // One-cycle memory and the external register file model
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem_byte(mem_addr);
        if (mem_req) begin
            req_cnt   <= req_cnt + 1;
            last_addr <= mem_addr;
        end
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) rf_dut[i] <= init_val(i);
        end else if (rf_wr_en) begin
            for (int l = 0; l < 4; l++)
                if (rf_wr_strb[l]) rf_dut[rf_wr_idx][l*8 +: 8] <= rf_wr_data[l*8 +: 8];
        end
    end

    task automatic check(input logic ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Reference model of one run, written from the requirements
    task automatic ref_run(input vec_t v, output int res, output logic m,
                           output int k, output logic [31:0] la);
        logic [31:0] a;
        logic [4:0]  r;
        logic [7:0]  b;
        int          lane;
        a = v.addr; r = v.sreg; lane = 3;
        res = int'(v.cnt); m = 1'b0; k = 0; la = '0;
        for (int i = 0; i < int'(v.cnt); i++) begin
            b = mem_byte(a);
            la = a;
            k++;
            if (r != v.pb && (v.pa == 5'd0 || r != v.pa)) rf_exp[r][lane*8 +: 8] = b;
            if (b == v.cmp) begin
                res = i; m = 1'b1;
                break;
            end
            if (lane == 0) begin
                lane = 3; r = r + 5'd1;
            end else begin
                lane--;
            end
            a = a + 32'd1;
        end
    endtask

    task automatic drive_start(input vec_t v);
        start_addr = v.addr; start_reg = v.sreg; prot_a_reg = v.pa;
        prot_b_reg = v.pb; byte_count = v.cnt; cmp_byte = v.cmp;
        start = 1'b1;
    endtask

    // Wait for done; lat counts rising edges since the start edge
    task automatic wait_done(output int lat);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_rf(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < 32; i++) if (rf_dut[i] !== rf_exp[i]) bad++;
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int          res, k, lat, snap;
        logic        m;
        logic [31:0] la;
        vec_t        v;

        for (int i = 0; i < 32; i++) rf_exp[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(!busy && !done && !mem_req && !rf_wr_en, "R10 reset controls",
              {busy, done, mem_req, rf_wr_en}, 0);
        check(proc_count == 0 && !matched, "R10 reset results", {matched, proc_count}, 0);

        // Table walk
        for (int t = 0; t < 9; t++) begin
            v = VECS[t];
            ref_run(v, res, m, k, la);
            snap = req_cnt;
            @(negedge clk);
            drive_start(v);
            wait_done(lat);
            check(proc_count == 7'(res), $sformatf("R6 count vec %0d", t), proc_count, res);
            check(matched == m, $sformatf("R5 matched vec %0d", t), matched, m);
            check(lat == 3 * k + 1, $sformatf("R9 latency vec %0d", t), lat, 3 * k + 1);
            @(negedge clk);
            check(req_cnt - snap == k, $sformatf("R7 reads vec %0d", t), req_cnt - snap, k);
            check(last_addr == la, $sformatf("R7 last address vec %0d", t), last_addr, la);
            check_rf($sformatf("R2 R3 R4 register file vec %0d", t));
        end

        // R9: cycle-exact single-byte run
        v = '{32'h0000_0040, 5'd10, 5'd0, 5'd0, 7'd1, 8'h00};
        ref_run(v, res, m, k, la);
        drive_start(v);
        @(negedge clk);
        start = 1'b0;
        check(mem_req && busy, "R9 request one cycle after start", mem_req, 1);
        @(negedge clk);
        check(!mem_req, "R9 request single cycle", mem_req, 0);
        @(negedge clk);
        check(rf_wr_en && rf_wr_strb == 4'b1000 && rf_wr_idx == 5'd10,
              "R9 R2 write after data", {rf_wr_en, rf_wr_strb, rf_wr_idx}, {1'b1, 4'b1000, 5'd10});
        @(negedge clk);
        check(done && proc_count == 7'd1, "R9 done after write", {done, proc_count}, {1'b1, 7'd1});
        @(negedge clk);
        check(!done, "R9 done one cycle", done, 0);
        check_rf("R3 single-byte lane");

        // R8: zero count
        snap = req_cnt;
        v = '{32'h0000_0600, 5'd2, 5'd0, 5'd0, 7'd0, 8'h00};
        drive_start(v);
        @(negedge clk);
        start = 1'b0;
        check(done && proc_count == 0 && !matched && !busy, "R8 zero count result",
              {done, matched, busy, proc_count}, {1'b1, 1'b0, 1'b0, 7'd0});
        repeat (3) @(negedge clk);
        check(req_cnt == snap, "R8 zero count no reads", req_cnt - snap, 0);
        check_rf("R8 zero count no writes");

        // R1: start while busy is ignored
        v = '{32'h0000_0200, 5'd24, 5'd0, 5'd0, 7'd8, 8'hFF};
        ref_run(v, res, m, k, la);
        snap = req_cnt;
        drive_start(v);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        drive_start('{32'h0000_0900, 5'd2, 5'd0, 5'd0, 7'd3, 8'h00});
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        check(proc_count == 7'(res) && matched == m, "R1 busy start ignored result",
              proc_count, res);
        repeat (4) @(negedge clk);
        check(!busy && req_cnt - snap == k, "R1 no second run", req_cnt - snap, k);
        check(last_addr == la, "R1 address of first run kept", last_addr, la);
        check_rf("R1 register file");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule